// File: doc/BRIEF.md
# UART Integration Test Register Harness

This block is a small bank of test registers on an APB slave port. It wraps the pin and intra-chip signals of a UART core so that software alone can check how the core is wired into a chip. A control register has three bits. One bit turns on integration test mode. One bit opens a direct path into the receive FIFO and out of the transmit FIFO. One bit keeps the receiver listening while the infrared encoder transmits.

In integration test mode, a combinational multiplexor on each signal replaces the core's value with a value held in a register. This covers the two DMA-clear inputs that enter the core, the four DMA requests and six interrupts that leave it, and the six primary output pins. Reading the registers back returns the multiplexor outputs, and for the primary input pins it returns the raw pins. The UART core and its FIFOs sit outside this block. The harness only produces single-cycle push and pop strobes for the FIFOs, together with the push data, and forwards the head of the transmit FIFO on a read.

Top module: `uart_test_harness`

## Requirements
- R1: After reset the control, input-test and output-test registers hold 0. Every multiplexed output then equals its functional source, and reading the control register returns 0.
- R2: While control bit 0 is 0, the outputs follow their functional sources: `dmaClr` follows `sysDmaClr`, `dmaReq` follows `coreDmaReq`, `irq` follows `coreIrq`, and `pinOut` follows `corePinOut`.
- R3: While control bit 0 is 1, `dmaClr[1]` (transmit clear) is driven from bit 7 of the input-test register (offset 0x084), and `dmaClr[0]` (receive clear) is driven from bit 6.
- R4: While control bit 0 is 1, `dmaReq[3:0]` (tx single, tx burst, rx single, rx burst) is driven from bits 15:12 of the output-test register (offset 0x088). `irq[5:0]` (modem status, receive, transmit, receive timeout, error, combined) is driven from bits 11:6.
- R5: While control bit 0 is 1, `pinOut[5:0]` (out2, out1, RTS, DTR, infrared out, serial TXD) is driven from output-test bits 5:0. Values written to these bits while test mode is off are stored, but they reach the pins only once test mode is turned on.
- R6: A read of offset 0x084 returns the current `dmaClr` in bits 7:6 and the raw `pinIn[5:0]` (ring, carrier detect, CTS, DSR, infrared in, serial RXD) in bits 5:0. All other bits read 0.
- R7: A read of offset 0x088 returns the current `dmaReq` in bits 15:12 and the current `irq` in bits 11:6. Bits 5:0 and all higher bits read 0.
- R8: The control register (offset 0x080) reads back its 3 written bits. Bit 2 drives `irRxDuringTx`. Control state changes only on an APB write.
- R9: While control bit 1 is 1, a write to offset 0x08C pulses `rxFifoPush` for exactly one cycle, with `rxPushData` equal to `pwdata[10:0]`.
- R10: While control bit 1 is 1, a read of offset 0x08C pulses `txFifoPop` for exactly one cycle. `prdata[10:0]` then equals `txFifoHead` in that same cycle.
- R11: While control bit 1 is 0, accesses to offset 0x08C raise neither strobe, and a read of that offset returns 0.
- R12: Push and pop occur only in the APB access phase (`psel` and `penable` both high). They never occur in the setup phase.
- R13: A write to an address outside the four offsets changes no register, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W (12) | APB byte address |
| pwdata | input | DATA_W (32) | APB write data |
| prdata | output | DATA_W (32) | APB read data |
| sysDmaClr | input | 2 | Functional DMA clear inputs toward the core (1 = tx, 0 = rx) |
| dmaClr | output | 2 | Multiplexed DMA clear into the core |
| coreDmaReq | input | 4 | Functional DMA requests from the core |
| dmaReq | output | 4 | Multiplexed DMA requests |
| coreIrq | input | 6 | Functional interrupts from the core |
| irq | output | 6 | Multiplexed interrupts |
| corePinOut | input | 6 | Functional primary outputs from the core |
| pinOut | output | 6 | Multiplexed primary output pins |
| pinIn | input | 6 | Raw primary input pins |
| irRxDuringTx | output | 1 | Keep the receiver enabled during infrared transmit |
| rxFifoPush | output | 1 | Single-cycle receive FIFO push strobe |
| rxPushData | output | FIFO_W (11) | Data for the receive FIFO push |
| txFifoPop | output | 1 | Single-cycle transmit FIFO pop strobe |
| txFifoHead | input | FIFO_W (11) | Head entry of the transmit FIFO |

## Verification
The assertions assume the APB master follows the protocol. In particular, an access phase always follows a setup phase, so `penable` is never high on two adjacent cycles. This is why the single-cycle rule for the strobes holds, and why the checker can compare the strobes directly against the phase signals. The bench drives every transfer through one write task and one read task. Each task holds the setup phase and the access phase for one cycle each and then returns the bus to idle, so the stimulus never breaks that assumption.

// File: rtl/uart_th_pkg.sv
package uart_th_pkg;
  localparam int CLR_N   = 2;
  localparam int DMA_N   = 4;
  localparam int IRQ_N   = 6;
  localparam int PINO_N  = 6;
  localparam int PINI_N  = 6;
  // field placement inside the test registers (software-visible)
  localparam int IN_CLR_LSB  = PINI_N;
  localparam int OUT_IRQ_LSB = PINO_N;
  localparam int OUT_DMA_LSB = OUT_IRQ_LSB + IRQ_N;
  localparam int OUT_REG_W   = OUT_DMA_LSB + DMA_N;
  localparam int CTRL_W      = 3;
  // control bit roles
  localparam int CB_TEST = 0;
  localparam int CB_FIFO = 1;
  localparam int CB_IRRX = 2;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_IN, SEL_OUT, SEL_DATA
  } regSel_e;

  typedef struct packed {
    logic    wrCtrl;
    logic    wrIn;
    logic    wrOut;
    logic    push;
    logic    pop;
    regSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/uart_th_ctrl.sv
module uart_th_ctrl
  import uart_th_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFF_CTRL = 12'h080,
  parameter logic [ADDR_W-1:0] OFF_IN   = 12'h084,
  parameter logic [ADDR_W-1:0] OFF_OUT  = 12'h088,
  parameter logic [ADDR_W-1:0] OFF_DATA = 12'h08C
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              fifoTestEn,
  output strobes_t          stb
);
  logic    accessWr, accessRd;
  regSel_e hit;

  always_comb begin
    unique case (paddr)
      OFF_CTRL: hit = SEL_CTRL;
      OFF_IN:   hit = SEL_IN;
      OFF_OUT:  hit = SEL_OUT;
      OFF_DATA: hit = SEL_DATA;
      default:  hit = SEL_NONE;
    endcase
  end

  assign accessWr = psel && penable && pwrite;
  assign accessRd = psel && penable && !pwrite;

  always_comb begin
    stb        = '0;
    stb.rdSel  = psel ? hit : SEL_NONE;
    stb.wrCtrl = accessWr && (hit == SEL_CTRL);
    stb.wrIn   = accessWr && (hit == SEL_IN);
    stb.wrOut  = accessWr && (hit == SEL_OUT);
    stb.push   = accessWr && (hit == SEL_DATA) && fifoTestEn;
    stb.pop    = accessRd && (hit == SEL_DATA) && fifoTestEn;
  end
endmodule

// File: rtl/uart_th_dp.sv
module uart_th_dp
  import uart_th_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FIFO_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [CLR_N-1:0]  sysDmaClr,
  output logic [CLR_N-1:0]  dmaClr,
  input  logic [DMA_N-1:0]  coreDmaReq,
  output logic [DMA_N-1:0]  dmaReq,
  input  logic [IRQ_N-1:0]  coreIrq,
  output logic [IRQ_N-1:0]  irq,
  input  logic [PINO_N-1:0] corePinOut,
  output logic [PINO_N-1:0] pinOut,
  input  logic [PINI_N-1:0] pinIn,
  input  logic [FIFO_W-1:0] txFifoHead,
  output logic [FIFO_W-1:0] rxPushData,
  output logic              testEn,
  output logic              fifoTestEn,
  output logic              irRxDuringTx
);
  localparam int MUX_N = CLR_N + OUT_REG_W;

  logic [CTRL_W-1:0]    ctrlQ;
  logic [CLR_N-1:0]     inQ;
  logic [OUT_REG_W-1:0] outQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      inQ   <= '0;
      outQ  <= '0;
    end else begin
      if (stb.wrCtrl) ctrlQ <= pwdata[CTRL_W-1:0];
      if (stb.wrIn)   inQ   <= pwdata[IN_CLR_LSB +: CLR_N];
      if (stb.wrOut)  outQ  <= pwdata[OUT_REG_W-1:0];
    end
  end

  assign testEn       = ctrlQ[CB_TEST];
  assign fifoTestEn   = ctrlQ[CB_FIFO];
  assign irRxDuringTx = ctrlQ[CB_IRRX];
  assign rxPushData   = pwdata[FIFO_W-1:0];

  // one multiplexor per signal, all steered by the registered enable
  logic [MUX_N-1:0] funcVec, testVec, muxVec;
  assign funcVec = {sysDmaClr, coreDmaReq, coreIrq, corePinOut};
  assign testVec = {inQ, outQ};

  for (genvar b = 0; b < MUX_N; b++) begin : g_mux
    assign muxVec[b] = testEn ? testVec[b] : funcVec[b];
  end

  assign {dmaClr, dmaReq, irq, pinOut} = muxVec;

  always_comb begin
    prdata = '0;
    unique case (stb.rdSel)
      SEL_CTRL: prdata[CTRL_W-1:0] = ctrlQ;
      SEL_IN: begin
        prdata[IN_CLR_LSB +: CLR_N] = dmaClr;
        prdata[PINI_N-1:0]          = pinIn;
      end
      SEL_OUT: begin
        prdata[OUT_DMA_LSB +: DMA_N] = dmaReq;
        prdata[OUT_IRQ_LSB +: IRQ_N] = irq;
      end
      SEL_DATA: if (fifoTestEn) prdata[FIFO_W-1:0] = txFifoHead;
      default: prdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_test_harness.sv
module uart_test_harness
  import uart_th_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int FIFO_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [1:0]        sysDmaClr,
  output logic [1:0]        dmaClr,
  input  logic [3:0]        coreDmaReq,
  output logic [3:0]        dmaReq,
  input  logic [5:0]        coreIrq,
  output logic [5:0]        irq,
  input  logic [5:0]        corePinOut,
  output logic [5:0]        pinOut,
  input  logic [5:0]        pinIn,
  output logic              irRxDuringTx,
  output logic              rxFifoPush,
  output logic [FIFO_W-1:0] rxPushData,
  output logic              txFifoPop,
  input  logic [FIFO_W-1:0] txFifoHead
);
  strobes_t stb;
  logic     testEn, fifoTestEn;

  uart_th_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .fifoTestEn(fifoTestEn), .stb(stb)
  );

  uart_th_dp #(.DATA_W(DATA_W), .FIFO_W(FIFO_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pwdata(pwdata), .prdata(prdata),
    .sysDmaClr(sysDmaClr), .dmaClr(dmaClr),
    .coreDmaReq(coreDmaReq), .dmaReq(dmaReq),
    .coreIrq(coreIrq), .irq(irq),
    .corePinOut(corePinOut), .pinOut(pinOut),
    .pinIn(pinIn), .txFifoHead(txFifoHead), .rxPushData(rxPushData),
    .testEn(testEn), .fifoTestEn(fifoTestEn), .irRxDuringTx(irRxDuringTx)
  );

  assign rxFifoPush = stb.push;
  assign txFifoPop  = stb.pop;
endmodule

// File: rtl/uart_test_harness_chk.sv
module uart_test_harness_chk #(
  parameter int DATA_W = 32,
  parameter int FIFO_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic              rxFifoPush,
  input logic [FIFO_W-1:0] rxPushData,
  input logic              txFifoPop,
  input logic [FIFO_W-1:0] txFifoHead,
  input logic              testEn,
  input logic [1:0]        sysDmaClr,
  input logic [1:0]        dmaClr,
  input logic [3:0]        coreDmaReq,
  input logic [3:0]        dmaReq,
  input logic [5:0]        coreIrq,
  input logic [5:0]        irq,
  input logic [5:0]        corePinOut,
  input logic [5:0]        pinOut
);
  AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (!rstN)
    !testEn |-> (dmaClr == sysDmaClr && dmaReq == coreDmaReq &&
                 irq == coreIrq && pinOut == corePinOut)); // R2
  AST_MODE_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(testEn) |-> $past(psel && penable && pwrite)); // R8
  AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxFifoPush |=> !rxFifoPush); // R9
  AST_PUSH_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rxFifoPush |-> rxPushData == pwdata[FIFO_W-1:0]); // R9
  AST_POP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    txFifoPop |=> !txFifoPop); // R10
  AST_POP_DATA: assert property (@(posedge clk) disable iff (!rstN)
    txFifoPop |-> prdata[FIFO_W-1:0] == txFifoHead); // R10
  AST_PUSH_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    rxFifoPush |-> (psel && penable && pwrite)); // R12
  AST_POP_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    txFifoPop |-> (psel && penable && !pwrite)); // R12
endmodule

bind uart_test_harness uart_test_harness_chk #(.DATA_W(DATA_W), .FIFO_W(FIFO_W)) u_chk (
  .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
  .pwdata(pwdata), .prdata(prdata), .rxFifoPush(rxFifoPush),
  .rxPushData(rxPushData), .txFifoPop(txFifoPop), .txFifoHead(txFifoHead),
  .testEn(testEn), .sysDmaClr(sysDmaClr), .dmaClr(dmaClr),
  .coreDmaReq(coreDmaReq), .dmaReq(dmaReq), .coreIrq(coreIrq), .irq(irq),
  .corePinOut(corePinOut), .pinOut(pinOut)
);

// File: tb/uart_test_harness_bench.sv
module uart_test_harness_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;

  logic        clk = 0, rstN = 0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic [1:0]  sysDmaClr = '0, dmaClr;
  logic [3:0]  coreDmaReq = '0, dmaReq;
  logic [5:0]  coreIrq = '0, irq, corePinOut = '0, pinOut, pinIn = '0;
  logic        irRxDuringTx, rxFifoPush, txFifoPop;
  logic [10:0] rxPushData, txFifoHead = '0;

  int nChk = 0, nBad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_test_harness u_uart_test_harness (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .sysDmaClr(sysDmaClr), .dmaClr(dmaClr), .coreDmaReq(coreDmaReq), .dmaReq(dmaReq),
    .coreIrq(coreIrq), .irq(irq), .corePinOut(corePinOut), .pinOut(pinOut),
    .pinIn(pinIn), .irRxDuringTx(irRxDuringTx), .rxFifoPush(rxFifoPush),
    .rxPushData(rxPushData), .txFifoPop(txFifoPop), .txFifoHead(txFifoHead)
  );

  // vector table: stimulus then expected outputs
  localparam logic [2:0]  V_CTRL [NV] = '{3'b000, 3'b001, 3'b001, 3'b100};
  localparam logic [1:0]  V_IN   [NV] = '{2'b11, 2'b10, 2'b01, 2'b00};
  localparam logic [15:0] V_OUT  [NV] = '{16'hFFFF, 16'hA5C3, 16'h5A3C, 16'h0000};
  localparam logic [1:0]  V_CCLR [NV] = '{2'b01, 2'b01, 2'b00, 2'b10};
  localparam logic [3:0]  V_CDMA [NV] = '{4'b0101, 4'b0101, 4'b1111, 4'b0011};
  localparam logic [5:0]  V_CIRQ [NV] = '{6'b101010, 6'b101010, 6'b111111, 6'b000111};
  localparam logic [5:0]  V_CPIN [NV] = '{6'b110011, 6'b110011, 6'b000000, 6'b101101};
  localparam logic [5:0]  V_PIN  [NV] = '{6'h15, 6'h2A, 6'h3F, 6'h00};
  localparam logic [1:0]  E_CLR  [NV] = '{2'b01, 2'b10, 2'b01, 2'b10};
  localparam logic [3:0]  E_DMA  [NV] = '{4'b0101, 4'b1010, 4'b0101, 4'b0011};
  localparam logic [5:0]  E_IRQ  [NV] = '{6'b101010, 6'b010111, 6'b101000, 6'b000111};
  localparam logic [5:0]  E_PIN  [NV] = '{6'b110011, 6'b000011, 6'b111100, 6'b101101};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FIL%s %s: actual=%h expected=%h", "", req, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [11:0] a, input logic [31:0] d,
                          output logic pushSeen, output logic [10:0] pushD);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    #1 chk("R12 no push in setup", {31'b0, rxFifoPush}, 32'd0);
    @(negedge clk);
    penable = 1;
    #1 pushSeen = rxFifoPush; pushD = rxPushData;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apbRead(input logic [11:0] a, output logic [31:0] d, output logic popSeen);
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    #1 chk("R12 no pop in setup", {31'b0, txFifoPop}, 32'd0);
    @(negedge clk);
    penable = 1;
    #1 d = prdata; popSeen = txFifoPop;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic        pu, po;
    logic [10:0] pd;
    corePinOut = 6'b011010; coreIrq = 6'b100001; coreDmaReq = 4'b1001; sysDmaClr = 2'b10;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    #1 chk("R1 pins after reset", {26'b0, pinOut}, {26'b0, corePinOut});
    chk("R1 irq after reset", {26'b0, irq}, {26'b0, coreIrq});
    chk("R1 dma after reset", {28'b0, dmaReq}, {28'b0, coreDmaReq});
    chk("R1 clr after reset", {30'b0, dmaClr}, {30'b0, sysDmaClr});
    apbRead(12'h080, rd, po);
    chk("R1 ctrl reads 0", rd, 32'd0);

    // table walk: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      sysDmaClr = V_CCLR[i]; coreDmaReq = V_CDMA[i]; coreIrq = V_CIRQ[i];
      corePinOut = V_CPIN[i]; pinIn = V_PIN[i];
      apbWrite(12'h084, {24'b0, V_IN[i], 6'b111111}, pu, pd);
      apbWrite(12'h088, {16'hFFFF, V_OUT[i]}, pu, pd);
      apbWrite(12'h080, {29'h1FFFFFFF, V_CTRL[i]}, pu, pd);
      #1;
      chk($sformatf("R2/R3 clr v%0d", i), {30'b0, dmaClr}, {30'b0, E_CLR[i]});
      chk($sformatf("R2/R4 dma v%0d", i), {28'b0, dmaReq}, {28'b0, E_DMA[i]});
      chk($sformatf("R2/R4 irq v%0d", i), {26'b0, irq}, {26'b0, E_IRQ[i]});
      chk($sformatf("R2/R5 pins v%0d", i), {26'b0, pinOut}, {26'b0, E_PIN[i]});
      chk($sformatf("R8 irRx v%0d", i), {31'b0, irRxDuringTx}, {31'b0, V_CTRL[i][2]});
      apbRead(12'h084, rd, po);
      chk($sformatf("R6 in read v%0d", i), rd, {24'b0, E_CLR[i], V_PIN[i]});
      apbRead(12'h088, rd, po);
      chk($sformatf("R7 out read v%0d", i), rd, {16'b0, E_DMA[i], E_IRQ[i], 6'b0});
      apbRead(12'h080, rd, po);
      chk($sformatf("R8 ctrl read v%0d", i), rd, {29'b0, V_CTRL[i]});
    end

    // R5: stored while off, applied when on
    corePinOut = 6'b000000;
    apbWrite(12'h080, 32'd0, pu, pd);
    apbWrite(12'h088, 32'h0000_002D, pu, pd);
    #1 chk("R5 pins unaffected while off", {26'b0, pinOut}, 32'd0);
    apbWrite(12'h080, 32'd1, pu, pd);
    #1 chk("R5 stored pins applied", {26'b0, pinOut}, 32'h2D);

    // R9 / R10 FIFO test access
    apbWrite(12'h080, 32'd2, pu, pd);
    apbWrite(12'h08C, 32'hFFFF_FFFF, pu, pd);
    chk("R9 push pulse", {31'b0, pu}, 32'd1);
    chk("R9 push data", {21'b0, pd}, 32'h7FF);
    #1 chk("R9 push ends after access", {31'b0, rxFifoPush}, 32'd0);
    txFifoHead = 11'h4AB;
    apbRead(12'h08C, rd, po);
    chk("R10 pop pulse", {31'b0, po}, 32'd1);
    chk("R10 pop data", rd, 32'h4AB);
    #1 chk("R10 pop ends after access", {31'b0, txFifoPop}, 32'd0);

    // R11 FIFO test off
    apbWrite(12'h080, 32'd0, pu, pd);
    apbWrite(12'h08C, 32'h0000_0123, pu, pd);
    chk("R11 no push when off", {31'b0, pu}, 32'd0);
    apbRead(12'h08C, rd, po);
    chk("R11 no pop when off", {31'b0, po}, 32'd0);
    chk("R11 data reads 0 when off", rd, 32'd0);

    // R13 unmapped address
    apbWrite(12'h080, 32'd5, pu, pd);
    apbWrite(12'h090, 32'hFFFF_FFFF, pu, pd);
    apbWrite(12'h081, 32'h0000_0002, pu, pd);
    apbRead(12'h090, rd, po);
    chk("R13 unmapped reads 0", rd, 32'd0);
    apbRead(12'h080, rd, po);
    chk("R13 ctrl untouched", rd, 32'd5);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule